// File: doc/BRIEF.md
# Transmit Frame Pad and CRC Appender

This block sits in the transmit path of an Ethernet MAC, between the frame source and the serialiser. It receives one frame at a time as a byte stream with valid, ready and last-byte handshakes. With the first byte of each frame it samples a 16-bit control word that carries two per-frame options: CRC inhibit and padding disable. The payload bytes are forwarded unchanged. When padding is allowed, short frames are extended with zero bytes. Unless CRC is inhibited, the 32-bit Ethernet frame check sequence is appended.

Padding always fills the frame to 60 data bytes. With CRC enabled, the four check bytes then bring the frame to 64 bytes. With CRC inhibited, the frame ends at 60 bytes. When padding is disabled, short frames leave as runts.

A frame of fewer than three bytes is never sent. To enforce this, the first two bytes of every frame are held inside the block. Output starts only when a third byte arrives. A frame that ends earlier is consumed completely, and its discard is reported by a one-cycle pulse.

Top module: `txf_pad_fcs`

## Requirements
- R1: After reset, out_valid and drop_pulse are 0 and in_ready is 1.
- R2: The data bytes of every frame of three or more bytes appear on the output in order, each value unchanged, with no byte lost or duplicated.
- R3: When control bit 13 (padding disable) is 0 and control bit 12 (CRC inhibit) is 0, a frame with fewer than 60 data bytes is followed by 0x00 bytes up to 60 bytes, then by 4 check bytes, for 64 bytes in total.
- R4: When bit 13 is 0 and bit 12 is 1, a short frame is padded with 0x00 to exactly 60 bytes and no check bytes are added.
- R5: When bit 13 is 1 and bit 12 is 0, no pad bytes are added, and the check bytes follow the last data byte directly.
- R6: When bit 13 is 1 and bit 12 is 1, the frame is sent exactly as given, with no pad bytes and no check bytes.
- R7: A frame of 1 or 2 bytes has every byte accepted, produces no output byte, and raises drop_pulse for exactly one cycle.
- R8: The check value is the reflected CRC-32 (polynomial 0xEDB88320 in reflected form, initial value 0xFFFFFFFF, final complement). It covers all data and pad bytes and is emitted least significant byte first.
- R9: The control word is sampled only when the first byte of a frame is accepted. Its value on the later bytes of the frame has no effect.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R11: out_last is 1 only on the final output byte of each frame: the last check byte, or the last data or pad byte when CRC is inhibited.
- R12: A frame with 60 or more data bytes gets no pad bytes in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Frame byte in |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | in_data is the last byte of the frame |
| in_ctrl | input | 16 | Per-frame control word, sampled with the first byte (bit 12 CRC inhibit, bit 13 padding disable) |
| in_ready | output | 1 | Block accepts in_data this cycle |
| out_data | output | 8 | Frame byte out |
| out_valid | output | 1 | out_data is valid |
| out_last | output | 1 | out_data is the last byte of the frame |
| out_ready | input | 1 | Downstream accepts out_data |
| drop_pulse | output | 1 | One-cycle pulse when a frame under three bytes is discarded |

## Verification
Directed frames of 1, 2, 3, 59, 60, 61 and 64 bytes are run in all four control modes. These lengths separate the discard boundary, the pad boundary and the case where no pad is needed, and show that each mode selects its own pad target and check-byte rule. Random frames of 1 to 90 bytes follow, with random modes, random input gaps and random output backpressure. Each of these frames carries a random control word on every byte after the first. A wrong latch point, a lost or repeated byte under stall, or a wrong CRC byte order therefore shows up as a byte mismatch against the bench's own model.

// File: rtl/txf_pkg.sv
package txf_pkg;

   typedef enum logic [2:0] {
      S_HOLD0,
      S_HOLD1,
      S_RUN,
      S_FLUSH,
      S_PAD,
      S_FCS
   } txf_state_e;

   localparam logic [31:0] FCS_POLY_REFL = 32'hEDB88320;
   localparam logic [31:0] FCS_SEED      = 32'hFFFFFFFF;

   function automatic logic [31:0] fcs_step(input logic [31:0] acc, input logic [7:0] b);
      logic [31:0] r;
      r = acc ^ {24'h0, b};
      for (int i = 0; i < 8; i++) begin
         r = r[0] ? ((r >> 1) ^ FCS_POLY_REFL) : (r >> 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/txf_crc_acc.sv
module txf_crc_acc #(
   parameter int FCS_BYTES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      upd,
   input  logic [7:0]                din,
   output logic [8*FCS_BYTES-1:0]    fcs
);
   import txf_pkg::*;

   localparam int FW = 8 * FCS_BYTES;

   if (FW != 32) begin : g_bad_width
      $error("txf_crc_acc: only a 32-bit check value is supported");
   end

   logic [FW-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= FCS_SEED;
      else if (clr) acc_q <= FCS_SEED;
      else if (upd) acc_q <= fcs_step(acc_q, din);
   end

   for (genvar k = 0; k < FCS_BYTES; k++) begin : g_lane
      assign fcs[8*k +: 8] = ~acc_q[8*k +: 8];
   end

   // R8: a new frame never restarts the accumulator while a byte is folded in
   assert_clr_upd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && upd));

endmodule

// File: rtl/txf_len_cnt.sv
module txf_len_cnt #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [LEN_W-1:0] cnt
);
   localparam logic [LEN_W-1:0] CNT_MAX = '1;

   if (LEN_W < 7) begin : g_bad_len
      $error("txf_len_cnt: LEN_W too small for the pad target");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/txf_out_reg.sv
module txf_out_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] ld_data,
   input  logic          ld_last,
   output logic          can_ld,
   output logic [DW-1:0] out_data,
   output logic          out_valid,
   output logic          out_last,
   input  logic          out_ready
);

   assign can_ld = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (ld) begin
         out_valid <= 1'b1;
         out_data  <= ld_data;
         out_last  <= ld_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R10: a stalled byte stays put
   assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R10: the sequencer never overwrites a byte that is still waiting
   assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ld |-> (!out_valid || out_ready));

endmodule

// File: rtl/txf_pad_fcs.sv
module txf_pad_fcs #(
   parameter int DW           = 8,
   parameter int CTRL_W       = 16,
   parameter int CRC_INH_BIT  = 12,
   parameter int PAD_DIS_BIT  = 13,
   parameter int MIN_FCS_DATA = 60,
   parameter int MIN_RAW      = 60,
   parameter int FCS_BYTES    = 4,
   parameter int LEN_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     in_data,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic [CTRL_W-1:0] in_ctrl,
   output logic              in_ready,
   output logic [DW-1:0]     out_data,
   output logic              out_valid,
   output logic              out_last,
   input  logic              out_ready,
   output logic              drop_pulse
);
   import txf_pkg::*;

   localparam int IDX_W = $clog2(FCS_BYTES);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);
   localparam logic [LEN_W:0] TGT_FCS = (LEN_W + 1)'(MIN_FCS_DATA);
   localparam logic [LEN_W:0] TGT_RAW = (LEN_W + 1)'(MIN_RAW);

   if (DW != 8) begin : g_bad_dw
      $error("txf_pad_fcs: byte stream only");
   end
   if (CRC_INH_BIT >= CTRL_W || PAD_DIS_BIT >= CTRL_W || CRC_INH_BIT == PAD_DIS_BIT) begin : g_bad_bits
      $error("txf_pad_fcs: control bit positions invalid");
   end
   if (MIN_FCS_DATA < 3 || MIN_RAW < 3 || MIN_FCS_DATA >= (1 << LEN_W) || MIN_RAW >= (1 << LEN_W)) begin : g_bad_min
      $error("txf_pad_fcs: pad targets out of range");
   end

   txf_state_e state_q, state_d;
   logic [7:0] hb0_q, hb0_d, hb1_q, hb1_d;
   logic       two_q, two_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic       pad_dis_q, crc_inh_q;
   logic       drop_q, drop_d;

   logic       acc, start, emit, emit_last, emit_upd, can_ld;
   logic [7:0] emit_byte;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W:0]   cnt_p1, target;
   logic [8*FCS_BYTES-1:0] fcs;
   logic       need_pad;
   logic       unused_ctrl;

   assign unused_ctrl = ^in_ctrl;

   assign acc    = in_valid && in_ready;
   assign start  = acc && (state_q == S_HOLD0);
   assign cnt_p1 = {1'b0, cnt} + 1'b1;
   assign target = crc_inh_q ? TGT_RAW : TGT_FCS;
   assign need_pad = !pad_dis_q && (cnt_p1 < target);

   always_comb begin
      unique case (state_q)
         S_HOLD0, S_HOLD1: in_ready = 1'b1;
         S_RUN:            in_ready = can_ld;
         default:          in_ready = 1'b0;
      endcase
   end

   always_comb begin
      state_d   = state_q;
      hb0_d     = hb0_q;
      hb1_d     = hb1_q;
      two_d     = two_q;
      idx_d     = idx_q;
      drop_d    = 1'b0;
      emit      = 1'b0;
      emit_upd  = 1'b0;
      emit_last = 1'b0;
      emit_byte = hb0_q;
      unique case (state_q)
         S_HOLD0: if (acc) begin
            if (in_last) drop_d = 1'b1;
            else begin
               hb0_d   = in_data;
               state_d = S_HOLD1;
            end
         end
         S_HOLD1: if (acc) begin
            if (in_last) begin
               drop_d  = 1'b1;
               state_d = S_HOLD0;
            end else begin
               hb1_d   = in_data;
               state_d = S_RUN;
            end
         end
         S_RUN: if (acc) begin
            emit     = 1'b1;
            emit_upd = 1'b1;
            hb0_d    = hb1_q;
            hb1_d    = in_data;
            if (in_last) begin
               two_d   = 1'b1;
               state_d = S_FLUSH;
            end
         end
         S_FLUSH: if (can_ld) begin
            emit     = 1'b1;
            emit_upd = 1'b1;
            hb0_d    = hb1_q;
            if (two_q) two_d = 1'b0;
            else begin
               emit_last = crc_inh_q && !need_pad;
               idx_d     = '0;
               if (need_pad)        state_d = S_PAD;
               else if (!crc_inh_q) state_d = S_FCS;
               else                 state_d = S_HOLD0;
            end
         end
         S_PAD: if (can_ld) begin
            emit      = 1'b1;
            emit_upd  = 1'b1;
            emit_byte = 8'h00;
            if (!need_pad) begin
               emit_last = crc_inh_q;
               idx_d     = '0;
               state_d   = crc_inh_q ? S_HOLD0 : S_FCS;
            end
         end
         S_FCS: if (can_ld) begin
            emit      = 1'b1;
            emit_byte = fcs[{idx_q, 3'b000} +: 8];
            emit_last = (idx_q == IDX_LAST);
            idx_d     = idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_d = S_HOLD0;
         end
         default: state_d = S_HOLD0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_HOLD0;
         hb0_q     <= '0;
         hb1_q     <= '0;
         two_q     <= 1'b0;
         idx_q     <= '0;
         drop_q    <= 1'b0;
         pad_dis_q <= 1'b0;
         crc_inh_q <= 1'b0;
      end else begin
         state_q <= state_d;
         hb0_q   <= hb0_d;
         hb1_q   <= hb1_d;
         two_q   <= two_d;
         idx_q   <= idx_d;
         drop_q  <= drop_d;
         if (start) begin
            pad_dis_q <= in_ctrl[PAD_DIS_BIT];
            crc_inh_q <= in_ctrl[CRC_INH_BIT];
         end
      end
   end

   assign drop_pulse = drop_q;

   txf_len_cnt #(.LEN_W(LEN_W)) u_len (
      .clk (clk),
      .rst_n (rst_n),
      .clr (start),
      .inc (emit && emit_upd),
      .cnt (cnt)
   );

   txf_crc_acc #(.FCS_BYTES(FCS_BYTES)) u_crc (
      .clk (clk),
      .rst_n (rst_n),
      .clr (start),
      .upd (emit && emit_upd),
      .din (emit_byte),
      .fcs (fcs)
   );

   txf_out_reg #(.DW(DW)) u_out (
      .clk (clk),
      .rst_n (rst_n),
      .ld (emit),
      .ld_data (emit_byte),
      .ld_last (emit_last),
      .can_ld (can_ld),
      .out_data (out_data),
      .out_valid (out_valid),
      .out_last (out_last),
      .out_ready (out_ready)
   );

   // R3: check bytes of a padded frame only start once the pad target is reached
   assert_fcs_after_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && state_q == S_FCS && !pad_dis_q) |-> ({1'b0, cnt} >= TGT_FCS));

   // R7: a discard pulse follows an accepted last byte
   assert_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      drop_pulse |-> $past(in_valid && in_ready && in_last));

   // R9: control options hold steady inside a frame
   assert_ctrl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_HOLD0) |=> (state_q == S_HOLD0 || ($stable(pad_dis_q) && $stable(crc_inh_q))));

endmodule

// File: tb/txf_pad_fcs_tb.sv
module txf_pad_fcs_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam int PAD_TGT    = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_last = 1'b0;
   logic [15:0] in_ctrl = '0;
   logic        in_ready;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_last;
   logic        out_ready = 1'b0;
   logic        drop_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_drops = 0;
   int seen_drops = 0;
   bit finished = 1'b0;
   bit mon_on = 1'b0;

   logic [8:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   txf_pad_fcs u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_data (in_data), .in_valid (in_valid), .in_last (in_last), .in_ctrl (in_ctrl),
      .in_ready (in_ready),
      .out_data (out_data), .out_valid (out_valid), .out_last (out_last),
      .out_ready (out_ready), .drop_pulse (drop_pulse)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
      logic [31:0] c = 32'hFFFFFFFF;
      foreach (b[i]) begin
         for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ b[i][k];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
         end
      end
      return ~c;
   endfunction

   // Expected output of one frame, from the requirements
   task automatic expect_frame(input logic [7:0] d[$], input bit pad_dis, input bit crc_inh);
      logic [7:0] body[$];
      string      tg[$];
      logic [31:0] c;
      if (d.size() < 3) begin
         exp_drops++;
         return;
      end
      body = d;
      foreach (d[i]) tg.push_back("R2");
      if (!pad_dis) begin
         while (body.size() < PAD_TGT) begin
            body.push_back(8'h00);
            tg.push_back(crc_inh ? "R4" : "R3");
         end
      end
      if (!crc_inh) begin
         c = ref_crc(body);
         for (int k = 0; k < 4; k++) begin
            body.push_back(c[8*k +: 8]);
            tg.push_back(pad_dis ? "R5/R8" : "R8");
         end
      end
      foreach (body[i]) begin
         exp_q.push_back({(i == body.size() - 1), body[i]});
         tag_q.push_back((crc_inh && pad_dis) ? "R6" : tg[i]);
      end
   endtask

   task automatic send_frame(input int len, input bit pad_dis, input bit crc_inh);
      logic [7:0] d[$];
      logic [15:0] ctrl;
      for (int i = 0; i < len; i++) d.push_back(8'($urandom));
      ctrl = 16'($urandom);
      ctrl[13] = pad_dis;
      ctrl[12] = crc_inh;
      expect_frame(d, pad_dis, crc_inh);
      for (int i = 0; i < len; i++) begin
         bit done = 1'b0;
         while (!done) begin
            @(negedge clk);
            if ($urandom_range(0, 5) == 0) begin
               in_valid = 1'b0;
            end else begin
               in_valid = 1'b1;
               in_data  = d[i];
               in_last  = (i == len - 1);
               // R9: after the first byte the control word is random junk
               in_ctrl  = (i == 0) ? ctrl : 16'($urandom);
               #(CLK_PERIOD/4);
               if (in_ready) done = 1'b1;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Output monitor: random backpressure, byte compare, stall hold
   logic [7:0] st_data;
   logic       st_last;
   bit         stalled = 1'b0;
   always @(negedge clk) begin
      if (mon_on) begin
         out_ready = ($urandom_range(0, 3) != 0);
         #(CLK_PERIOD/4);
         if (drop_pulse) seen_drops++;
         if (stalled) begin
            check(out_valid && out_data == st_data && out_last == st_last, "R10",
                  {out_valid, out_last, out_data}, {1'b1, st_last, st_data});
         end
         stalled = out_valid && !out_ready;
         st_data = out_data;
         st_last = out_last;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 extra byte", out_data, 0);
            end else begin
               logic [8:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_data == e[7:0], t, out_data, e[7:0]);
               check(out_last == e[8], "R11", out_last, e[8]);
            end
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD/4);
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(drop_pulse == 1'b0, "R1 drop_pulse", drop_pulse, 0);
      check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
      mon_on = 1'b1;

      // Directed: discard edge, pad edge and long frames (R12) in every mode
      for (int m = 0; m < 4; m++) begin
         send_frame(1,  m[1], m[0]);
         send_frame(2,  m[1], m[0]);
         send_frame(3,  m[1], m[0]);
         send_frame(59, m[1], m[0]);
         send_frame(60, m[1], m[0]);
         send_frame(61, m[1], m[0]);
         send_frame(64, m[1], m[0]);
      end
      // Random frames
      for (int f = 0; f < 200; f++) begin
         send_frame($urandom_range(1, 90), 1'($urandom), 1'($urandom));
      end

      for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R2 missing bytes", exp_q.size(), 0);
      check(seen_drops == exp_drops, "R7 drop count", seen_drops, exp_drops);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R2 actual=%0d expected=0", exp_q.size());
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule